// File: doc/BRIEF.md
# Eight-Queue Transmit Channel Scheduler

This block decides which of eight transmit queues a DMA engine serves next. A queue becomes eligible when the host writes a non-zero head descriptor pointer for it. It stays eligible until the DMA side finishes a packet on that queue and reports that the queue's descriptor list has run out. A packet can span several descriptors, so a grant covers a whole packet. The grant is held until the DMA side pulses packet-done.

One configuration input selects the service order. In fixed-priority mode the highest-numbered eligible queue always wins. In round-robin mode the search begins at the queue after the one granted most recently and wraps around. After every packet-done the grant is withdrawn for one cycle. The next grant is then taken from the eligibility flags as they stand after that packet.

Top module: `txq_sched`

## Requirements
- R1: After reset no queue is eligible, grant_valid is 0 and grant_ch is 0.
- R2: A write with hp_wr_en high and non-zero hp_wr_data makes queue hp_wr_ch eligible at that edge. If no grant is held, grant_valid rises at the following edge, so the grant shows two edges after the write was presented.
- R3: A head pointer write whose data is zero does not make the queue eligible.
- R4: With rr_mode = 0 a new grant goes to the highest-numbered eligible queue (queue 7 first, queue 0 last).
- R5: With rr_mode = 1 a new grant goes to the first eligible queue found by counting upward from the most recently granted queue plus one, modulo 8. Before the first grant the search starts at queue 0.
- R6: While grant_valid is 1 and pkt_done is 0, grant_valid and grant_ch do not change, whatever writes or mode changes occur.
- R7: pkt_done while a grant is held drops grant_valid at the next edge. If any queue is still eligible, a new grant appears one edge later. With list_end = 0 the granted queue stays eligible.
- R8: pkt_done together with list_end = 1 during a grant makes the granted queue ineligible. Other queues are not affected.
- R9: A non-zero head pointer write to the granted queue in the same cycle as its pkt_done with list_end = 1 leaves that queue eligible.
- R10: pkt_done and list_end have no effect while grant_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hp_wr_en | input | 1 | Head pointer write strobe |
| hp_wr_ch | input | 3 | Queue addressed by the write |
| hp_wr_data | input | 32 | Head pointer value, zero means no list |
| rr_mode | input | 1 | 1 = round-robin, 0 = fixed priority |
| pkt_done | input | 1 | Current packet finished |
| list_end | input | 1 | Granted queue has no further descriptors (valid with pkt_done) |
| grant_valid | output | 1 | A queue is granted |
| grant_ch | output | 3 | Granted queue number |

## Verification
On every cycle the assertions check several properties: the grant is held without pkt_done, it drops after pkt_done, a granted queue is always eligible, zero writes never make a queue eligible, retirement clears the flag, and a fresh fixed-priority grant has no eligible queue above it. The round-robin order depends on history, so the bench scenarios show it. They sweep every eligibility pattern in both modes and compare each grant with a cycle model. The same scenarios cover the write-versus-retire collision and the one-cycle gap between packets.

// File: rtl/txq_sched_pkg.sv
package txq_sched_pkg;

    localparam int CH_NUM = 8;
    localparam int CH_W   = $clog2(CH_NUM);
    localparam int PTR_W  = 32;

    typedef logic [CH_W-1:0] ch_idx_t;

    typedef enum logic {
        SVC_FIXED = 1'b0,
        SVC_RR    = 1'b1
    } svc_mode_e;

    typedef struct packed {
        logic    valid;
        ch_idx_t ch;
    } grant_t;

    typedef struct packed {
        logic    en;
        ch_idx_t ch;
    } ch_evt_t;

    function automatic svc_mode_e mode_from_bit(input logic b);
        return b ? SVC_RR : SVC_FIXED;
    endfunction

endpackage

// File: rtl/txq_act_track.sv
module txq_act_track
    import txq_sched_pkg::*;
#(
    parameter int NUM_CH = CH_NUM,
    parameter int IDX_W  = CH_W,
    parameter int P_W    = PTR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  ch_evt_t           wr_evt,
    input  logic [P_W-1:0]    wr_ptr,
    input  ch_evt_t           retire_evt,
    output logic [NUM_CH-1:0] act_mask
);

    logic ptr_nonzero;
    assign ptr_nonzero = |wr_ptr;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic set_hit;
        logic clr_hit;
        assign set_hit = wr_evt.en && ptr_nonzero && (wr_evt.ch == IDX_W'(g));
        assign clr_hit = retire_evt.en && (retire_evt.ch == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                act_mask[g] <= 1'b0;
            end else if (set_hit) begin
                act_mask[g] <= 1'b1;
            end else if (clr_hit) begin
                act_mask[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/txq_arb_pick.sv
module txq_arb_pick
    import txq_sched_pkg::*;
#(
    parameter int NUM_CH = CH_NUM,
    parameter int IDX_W  = CH_W
) (
    input  logic [NUM_CH-1:0] act_mask,
    input  logic [IDX_W-1:0]  last_ch,
    input  svc_mode_e         mode,
    output logic              found,
    output logic [IDX_W-1:0]  pick_ch
);

    logic [IDX_W-1:0] fix_ch;
    logic [IDX_W-1:0] rr_ch;

    always_comb begin
        fix_ch = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (act_mask[i]) fix_ch = IDX_W'(i);
        end
    end

    always_comb begin
        rr_ch = '0;
        for (int k = NUM_CH; k >= 1; k--) begin
            int idx;
            idx = (int'(last_ch) + k) % NUM_CH;
            if (act_mask[idx]) rr_ch = IDX_W'(idx);
        end
    end

    assign found   = |act_mask;
    assign pick_ch = (mode == SVC_RR) ? rr_ch : fix_ch;

endmodule

// File: rtl/txq_grant_ctl.sv
module txq_grant_ctl
    import txq_sched_pkg::*;
#(
    parameter int IDX_W = CH_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             found,
    input  logic [IDX_W-1:0] pick_ch,
    input  logic             pkt_done,
    input  logic             list_end,
    output grant_t           grant,
    output logic [IDX_W-1:0] last_ch,
    output ch_evt_t          retire_evt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            grant.valid <= 1'b0;
            grant.ch    <= '0;
            last_ch     <= IDX_W'((1 << IDX_W) - 1);
        end else if (grant.valid) begin
            if (pkt_done) grant.valid <= 1'b0;
        end else if (found) begin
            grant.valid <= 1'b1;
            grant.ch    <= pick_ch;
            last_ch     <= pick_ch;
        end
    end

    assign retire_evt.en = grant.valid && pkt_done && list_end;
    assign retire_evt.ch = grant.ch;

endmodule

// File: rtl/txq_sched.sv
module txq_sched
    import txq_sched_pkg::*;
#(
    parameter int NUM_CH = CH_NUM,
    parameter int P_W    = PTR_W,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hp_wr_en,
    input  logic [IDX_W-1:0] hp_wr_ch,
    input  logic [P_W-1:0]   hp_wr_data,
    input  logic             rr_mode,
    input  logic             pkt_done,
    input  logic             list_end,
    output logic             grant_valid,
    output logic [IDX_W-1:0] grant_ch
);

    logic [NUM_CH-1:0] act_mask;
    logic [IDX_W-1:0]  last_ch;
    logic [IDX_W-1:0]  pick_ch;
    logic              found;
    ch_evt_t           wr_evt;
    ch_evt_t           retire_evt;
    grant_t            grant;

    assign wr_evt.en = hp_wr_en;
    assign wr_evt.ch = hp_wr_ch;

    txq_act_track #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .P_W(P_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .wr_evt     (wr_evt),
        .wr_ptr     (hp_wr_data),
        .retire_evt (retire_evt),
        .act_mask   (act_mask)
    );

    txq_arb_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick (
        .act_mask (act_mask),
        .last_ch  (last_ch),
        .mode     (mode_from_bit(rr_mode)),
        .found    (found),
        .pick_ch  (pick_ch)
    );

    txq_grant_ctl #(.IDX_W(IDX_W)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .found      (found),
        .pick_ch    (pick_ch),
        .pkt_done   (pkt_done),
        .list_end   (list_end),
        .grant      (grant),
        .last_ch    (last_ch),
        .retire_evt (retire_evt)
    );

    assign grant_valid = grant.valid;
    assign grant_ch    = grant.ch;

endmodule

// File: rtl/txq_sched_chk.sv
module txq_sched_chk #(
    parameter int NUM_CH = 8,
    parameter int P_W    = 32,
    parameter int IDX_W  = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             hp_wr_en,
    input logic [IDX_W-1:0] hp_wr_ch,
    input logic [P_W-1:0]   hp_wr_data,
    input logic             rr_mode,
    input logic             pkt_done,
    input logic             list_end,
    input logic             grant_valid,
    input logic [IDX_W-1:0] grant_ch,
    input logic [NUM_CH-1:0] act_mask
);

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        grant_valid && !pkt_done |=> grant_valid && $stable(grant_ch));

    assert_drop_R7: assert property (@(posedge clk) disable iff (rst)
        grant_valid && pkt_done |=> !grant_valid);

    assert_granted_active_R2: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> act_mask[grant_ch]);

    assert_zero_write_R3: assert property (@(posedge clk) disable iff (rst)
        hp_wr_en && (hp_wr_data == '0) && !act_mask[hp_wr_ch] |=> !act_mask[$past(hp_wr_ch)]);

    assert_retire_R8: assert property (@(posedge clk) disable iff (rst)
        grant_valid && pkt_done && list_end
        && !(hp_wr_en && (hp_wr_ch == grant_ch) && (hp_wr_data != '0))
        |=> !act_mask[$past(grant_ch)]);

    assert_fixed_top_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(grant_valid) && !$past(rr_mode) |-> ((($past(act_mask) >> grant_ch) >> 1) == '0));

    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !grant_valid && (act_mask == '0) |=> !grant_valid);

endmodule

bind txq_sched txq_sched_chk #(.NUM_CH(NUM_CH), .P_W(P_W), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .hp_wr_en    (hp_wr_en),
    .hp_wr_ch    (hp_wr_ch),
    .hp_wr_data  (hp_wr_data),
    .rr_mode     (rr_mode),
    .pkt_done    (pkt_done),
    .list_end    (list_end),
    .grant_valid (grant_valid),
    .grant_ch    (grant_ch),
    .act_mask    (act_mask)
);

// File: tb/txq_sched_bench.sv
module txq_sched_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hp_wr_en = 1'b0;
    logic [2:0]  hp_wr_ch = '0;
    logic [31:0] hp_wr_data = '0;
    logic        rr_mode = 1'b0;
    logic        pkt_done = 1'b0;
    logic        list_end = 1'b0;
    logic        grant_valid;
    logic [2:0]  grant_ch;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    logic [7:0] m_act;
    bit         m_gv;
    int         m_gch;
    int         m_last;

    always #10 clk = ~clk;

    txq_sched u_txq_sched (
        .clk(clk), .rst(rst), .hp_wr_en(hp_wr_en), .hp_wr_ch(hp_wr_ch),
        .hp_wr_data(hp_wr_data), .rr_mode(rr_mode), .pkt_done(pkt_done),
        .list_end(list_end), .grant_valid(grant_valid), .grant_ch(grant_ch)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int pick(input logic [7:0] m, input int last, input bit rr);
        if (rr) begin
            for (int k = 1; k <= 8; k++) begin
                if (m[(last + k) % 8]) return (last + k) % 8;
            end
        end else begin
            for (int i = 7; i >= 0; i--) begin
                if (m[i]) return i;
            end
        end
        return 0;
    endfunction

    task automatic model_reset();
        m_act = '0; m_gv = 0; m_gch = 0; m_last = 7;
    endtask

    // one clock: advance model with the inputs present at the edge, compare at negedge
    task automatic cyc();
        logic [7:0] na;
        @(posedge clk);
        na = m_act;
        if (m_gv) begin
            if (pkt_done) begin
                m_gv = 0;
                if (list_end) na[m_gch] = 1'b0;
            end
        end else if (m_act != 0) begin
            m_gv = 1;
            m_gch = pick(m_act, m_last, rr_mode);
            m_last = m_gch;
        end
        if (hp_wr_en && hp_wr_data != 0) na[hp_wr_ch] = 1'b1;
        m_act = na;
        @(negedge clk);
        check(rr_mode ? "R5 grant_valid" : "R4 grant_valid", int'(grant_valid), int'(m_gv));
        if (m_gv) check(rr_mode ? "R5 grant_ch" : "R4 grant_ch", int'(grant_ch), m_gch);
    endtask

    task automatic wr(input int ch, input int data);
        hp_wr_en = 1'b1; hp_wr_ch = 3'(ch); hp_wr_data = 32'(data);
    endtask

    task automatic idle();
        hp_wr_en = 1'b0; pkt_done = 1'b0; list_end = 1'b0;
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 grant_valid", int'(grant_valid), 0);
        check("R1 grant_ch", int'(grant_ch), 0);

        // R3 zero pointer does not activate
        wr(5, 0); cyc(); idle(); cyc(); cyc();
        check("R3 zero write grant_valid", int'(grant_valid), 0);

        // R2 latency: write, then one cycle later the grant
        wr(2, 32'h100); cyc();
        check("R2 no grant yet", int'(grant_valid), 0);
        idle(); cyc();
        check("R2 grant_valid", int'(grant_valid), 1);
        check("R2 grant_ch", int'(grant_ch), 2);

        // R6 hold against higher-priority activation and mode change
        wr(6, 32'h200); cyc(); idle(); rr_mode = 1'b1; cyc(); rr_mode = 1'b0; cyc();
        check("R6 hold grant_ch", int'(grant_ch), 2);
        check("R6 hold grant_valid", int'(grant_valid), 1);

        // R7 done without list end: gap then regrant, fixed mode picks 6 (R4)
        pkt_done = 1'b1; cyc(); idle();
        check("R7 gap", int'(grant_valid), 0);
        cyc();
        check("R4 fixed highest", int'(grant_ch), 6);

        // R8 retire 6, 2 remains
        pkt_done = 1'b1; list_end = 1'b1; cyc(); idle(); cyc();
        check("R8 other kept", int'(grant_ch), 2);
        check("R8 other kept valid", int'(grant_valid), 1);

        // R9 write and retire collide on granted queue
        pkt_done = 1'b1; list_end = 1'b1; wr(2, 32'h300); cyc(); idle(); cyc();
        check("R9 still granted", int'(grant_valid), 1);
        check("R9 grant_ch", int'(grant_ch), 2);

        // retire 2 -> empty
        pkt_done = 1'b1; list_end = 1'b1; cyc(); idle(); cyc();
        check("R8 empty", int'(grant_valid), 0);

        // R10 done while idle has no effect
        pkt_done = 1'b1; list_end = 1'b1; cyc(); cyc(); idle();
        wr(1, 32'h40); cyc(); idle(); cyc();
        check("R10 ignored then grant", int'(grant_ch), 1);
        pkt_done = 1'b1; list_end = 1'b1; cyc(); idle(); cyc();

        // sweep every eligibility pattern in both modes
        for (int mode = 0; mode < 2; mode++) begin
            rr_mode = mode[0];
            for (int mask = 0; mask < 256; mask++) begin
                for (int c = 0; c < 8; c++) begin
                    wr(c, mask[c] ? (c + 1) * 17 : 0);
                    cyc();
                end
                idle();
                for (int n = 0; n < 80; n++) begin
                    if (m_act == 0 && !m_gv) break;
                    pkt_done = grant_valid;
                    list_end = ((mask + n) % 3) != 0;
                    cyc();
                end
                idle();
                cyc();
            end
        end

        // random traffic
        for (int n = 0; n < 6000; n++) begin
            hp_wr_en   = ($urandom % 4) == 0;
            hp_wr_ch   = 3'($urandom % 8);
            hp_wr_data = (($urandom % 5) == 0) ? 32'd0 : 32'($urandom | 1);
            pkt_done   = ($urandom % 3) == 0;
            list_end   = ($urandom % 2) == 0;
            if (($urandom % 50) == 0) rr_mode = ~rr_mode;
            cyc();
        end
        idle();

        if (!done_flag) begin
            done_flag = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int n = 0; n < 150000; n++) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule